// File: doc/BRIEF.md
# NCO-Timed Serial Byte Transmitter

This block turns bytes into an asynchronous serial stream. A 32-bit control word written by the host holds a transmit-enable flag and a 16-bit rate increment. Bytes arrive through a valid/ready handshake. Each byte leaves on a single line as a ten-bit frame: a low start bit, the eight data bits with the least significant bit first, and a high stop bit. The line rests high between frames.

The bit rate does not come from an integer divider. A phase accumulator adds the increment on every clock, and each carry out of the accumulator is one oversample tick. Sixteen ticks make one bit period, so the bit rate equals increment × fclk / 2^20, with a resolution fine enough for arbitrary baud rates. A new increment takes effect on the ticks that follow the write, including those inside a frame already on the line.

Top module: `uart_nco_tx`

## Requirements
- R1: After reset the serial line is high and ready is low.
- R2: A frame is a 0 start bit, then data bits 0 through 7 in that order, then a 1 stop bit. The line is high whenever no frame is in progress.
- R3: Ready is high only when no frame is in progress, the enable bit is set and the increment is nonzero. No frame starts while the enable bit is clear, even with valid held high.
- R4: The control word places the enable at bit 0 and the increment at bits 31:16. Bits 15:1 are ignored.
- R5: Each bit lasts exactly 16 accumulator carries. One frame therefore lasts 160 carries, about 10 × 2^20 / increment clocks.
- R6: With an increment of zero no carries occur, ready stays low and the line stays high.
- R7: An increment written during a frame sets the length of the bits that follow within that same frame.
- R8: Clearing the enable bit during a frame lets that frame finish unchanged. After it, no new frame starts.
- R9: A byte offered while a frame is on the line is held off by ready and is sent intact after the current frame. The frame in flight is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word: enable at bit 0, increment at 31:16 |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Byte offered |
| tx_ready_o | output | 1 | Byte will be taken on this edge if valid |
| tx_o | output | 1 | Serial line, idle high |

## Verification
The assertions assume that the control word changes only through the write strobe, and that data and valid are stable around the clock edge. The bench drives every input on the falling edge, so this always holds. The line-level checks also assume that a bit period is much longer than the spacing between carries. To keep the mid-bit sample points unambiguous, random increments are drawn from 0x2000 to 0xFFFF, which gives bit periods of 16 to 128 clocks.

// File: rtl/uart_nco_pkg.sv
package uart_nco_pkg;
  localparam int unsigned CTRL_W   = 32;
  localparam int unsigned NCO_W    = 16;
  localparam int unsigned NCO_LSB  = 16;
  localparam int unsigned EN_BIT   = 0;

  typedef struct packed {
    logic [NCO_W-1:0]          inc;
    logic [CTRL_W-NCO_W-2:0]   unused;
    logic                      en;
  } ctrl_t;
endpackage

// File: rtl/uart_nco_ctrl.sv
module uart_nco_ctrl
  import uart_nco_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic              en_o,
  output logic [NCO_W-1:0]  inc_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (we_i) ctrl_q <= ctrl_t'(wdata_i);
  end

  assign en_o  = ctrl_q.en;
  assign inc_o = ctrl_q.inc;
endmodule

// File: rtl/uart_nco_tick.sv
module uart_nco_tick #(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] inc_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic             tick_q;

  assign sum = {1'b0, acc_q} + {1'b0, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= sum[ACC_W-1:0];
      tick_q <= sum[ACC_W];
    end
  end

  assign tick_o = tick_q;

  // R6: a carry needs a nonzero increment
  p_tick_needs_inc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(inc_i) != '0);
endmodule

// File: rtl/uart_nco_shifter.sv
module uart_nco_shifter #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              rate_ok_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              line_o
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned OVS_W   = $clog2(OVS);
  localparam int unsigned IDX_W   = $clog2(FRAME_W);

  logic               busy_q;
  logic [FRAME_W-1:0] sh_q;
  logic [OVS_W-1:0]   os_q;
  logic [IDX_W-1:0]   idx_q;
  logic               bit_end;

  assign ready_o = !busy_q && en_i && rate_ok_i;
  assign bit_end = tick_i && (os_q == OVS_W'(OVS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      os_q   <= '0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (valid_i && ready_o) begin
        busy_q <= 1'b1;
        sh_q   <= {1'b1, data_i, 1'b0};
        os_q   <= '0;
        idx_q  <= '0;
      end
    end else if (tick_i) begin
      os_q <= os_q + 1'b1;
      if (bit_end) begin
        sh_q <= {1'b1, sh_q[FRAME_W-1:1]};
        if (idx_q == IDX_W'(FRAME_W - 1)) busy_q <= 1'b0;
        else idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign line_o = busy_q ? sh_q[0] : 1'b1;

  p_start_needs_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(en_i) && $past(valid_i));
  p_start_bit_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> !line_o);
  p_stop_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(line_o));
  p_line_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !tick_i |=> $stable(line_o));
  p_idx_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < IDX_W'(FRAME_W));
endmodule

// File: rtl/uart_nco_tx.sv
module uart_nco_tx
  import uart_nco_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              tx_o
);
  logic             en;
  logic [NCO_W-1:0] inc;
  logic             tick;

  uart_nco_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .en_o    (en),
    .inc_o   (inc)
  );

  uart_nco_tick #(.ACC_W(NCO_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (inc),
    .tick_o (tick)
  );

  uart_nco_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .en_i      (en),
    .rate_ok_i (inc != '0),
    .data_i    (tx_data_i),
    .valid_i   (tx_valid_i),
    .ready_o   (tx_ready_o),
    .line_o    (tx_o)
  );

  p_ready_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> en && inc != '0);
endmodule

// File: tb/tb_uart_nco_tx.sv
module tb_uart_nco_tx;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_ni = 0;
  logic        ctrl_we = 0;
  logic [31:0] ctrl_wdata = '0;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 0;
  logic        tx_ready;
  logic        tx_line;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_nco_tx dut (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_o(tx_line)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: act %0d exp <190000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic chk_range(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: act %0d exp %0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic int ctrl_word(bit en, int inc);
    return (inc << 16) | int'(en);
  endfunction

  function automatic int mid_bit(int k, int inc);
    return ((2*k + 1) * (1 << 20)) / (2 * inc);
  endfunction

  function automatic int frame_len(int inc);
    return (10 * (1 << 20)) / inc;
  endfunction

  task automatic wr_ctrl(int w);
    ctrl_we = 1; ctrl_wdata = w;
    @(negedge clk);
    ctrl_we = 0;
  endtask

  // Sends b, optionally decodes it, optionally writes ctrl at clock mod_at.
  task automatic run_frame(input logic [7:0] b, input int inc, input bit decode,
                           input int mod_at, input int mod_val, input int max_cnt,
                           input bit keep_valid, input logic [7:0] next_b,
                           output int clks);
    int cnt = 0;
    int k = 0;
    logic [9:0] got = '0;
    tx_data = b; tx_valid = 1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = keep_valid; tx_data = next_b;
    clks = -1;
    while (1) begin
      if (cnt == mod_at) begin ctrl_we = 1; ctrl_wdata = mod_val; end
      else ctrl_we = 0;
      if (decode && k < 10 && cnt == mid_bit(k, inc)) begin
        got[k] = tx_line;
        k++;
      end
      if (cnt > 0 && tx_ready && !keep_valid) begin clks = cnt; break; end
      if (keep_valid && k == 10) break;
      if (cnt >= max_cnt) break;
      @(negedge clk);
      cnt++;
    end
    ctrl_we = 0;
    if (decode) begin
      chk("R2 start bit", int'(got[0]), 0);
      chk("R2 data bits", int'(got[8:1]), int'(b));
      chk("R2 stop bit", int'(got[9]), 1);
    end
  endtask

  initial begin
    int clks;
    int inc;
    logic [7:0] b;
    bit stayed;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    chk("R1 line idle in reset", int'(tx_line), 1);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 line idle", int'(tx_line), 1);
    chk("R1 ready low", int'(tx_ready), 0);

    // R4: bits 15:1 ignored, enable only at bit 0
    wr_ctrl(32'h0000_FFFE);
    chk("R4 reserved bits no enable", int'(tx_ready), 0);
    wr_ctrl(32'h4000_FFFE);
    chk("R4 increment alone no enable", int'(tx_ready), 0);

    // R3: enable clear, valid held high for a while
    tx_valid = 1; tx_data = 8'h5A;
    stayed = 1;
    repeat (300) begin @(negedge clk); if (!tx_line || tx_ready) stayed = 0; end
    chk("R3 no start while disabled", int'(stayed), 1);
    tx_valid = 0;

    // R6: enabled with zero increment
    wr_ctrl(ctrl_word(1, 0));
    tx_valid = 1;
    stayed = 1;
    repeat (300) begin @(negedge clk); if (!tx_line || tx_ready) stayed = 0; end
    chk("R6 zero increment idle", int'(stayed), 1);
    tx_valid = 0;

    // R4/R5 directed: increment 0x4000 -> 64-clock bits
    wr_ctrl(32'h4000_0001);
    chk("R3 ready when enabled", int'(tx_ready), 1);
    run_frame(8'hA5, 16'h4000, 1, -1, 0, 2000, 0, 8'h00, clks);
    chk_range("R5 frame length 0x4000", clks, 640 - 8, 640 + 8);
    chk("R2 idle high after frame", int'(tx_line), 1);
    run_frame(8'h00, 16'h4000, 1, -1, 0, 2000, 0, 8'h00, clks);
    run_frame(8'hFF, 16'h4000, 1, -1, 0, 2000, 0, 8'h00, clks);
    run_frame(8'h01, 16'h4000, 1, -1, 0, 2000, 0, 8'h00, clks);
    run_frame(8'h80, 16'h4000, 1, -1, 0, 2000, 0, 8'h00, clks);

    // R7: speed up mid-frame
    run_frame(8'h3C, 16'h4000, 0, 320, ctrl_word(1, 16'h8000), 2000, 0, 8'h00, clks);
    chk_range("R7 mid-frame rate change", clks, 440, 520);
    run_frame(8'hC3, 16'h8000, 1, -1, 0, 2000, 0, 8'h00, clks);
    chk_range("R7 next frame new rate", clks, 320 - 6, 320 + 6);

    // R9: second byte offered during the frame
    wr_ctrl(ctrl_word(1, 16'h4000));
    run_frame(8'h96, 16'h4000, 1, -1, 0, 2000, 1, 8'h69, clks);
    chk("R9 held off during frame", int'(tx_ready), 0);
    run_frame(8'h69, 16'h4000, 1, -1, 0, 2000, 0, 8'h00, clks);

    // R8: disable mid-frame; frame completes, nothing follows
    run_frame(8'hE7, 16'h4000, 1, 100, ctrl_word(0, 16'h4000), 660, 0, 8'h00, clks);
    tx_valid = 1; tx_data = 8'h11;
    stayed = 1;
    repeat (1500) begin @(negedge clk); if (!tx_line || tx_ready) stayed = 0; end
    chk("R8 no frame after disable", int'(stayed), 1);
    tx_valid = 0;

    // R5/R2 random
    for (int i = 0; i < 25; i++) begin
      inc = $urandom_range(16'hFFFF, 16'h2000);
      b = 8'($urandom);
      wr_ctrl(ctrl_word(1, inc));
      run_frame(b, inc, 1, -1, 0, 3000, 0, 8'h00, clks);
      chk_range("R5 random frame length", clks,
                frame_len(inc) - (65536 / inc) - 4, frame_len(inc) + (65536 / inc) + 4);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule